// File: doc/BRIEF.md
# Three-Port Register File

This block holds the general-purpose registers of a small load-store datapath. Two read ports and one write port share one storage array. Each read port takes a register number and returns that register's contents combinationally, so an operand fetch needs no clock cycle.

The write port takes a register number, a data word and an enable, and updates the array on the rising clock edge. Register zero is a constant source of zero on both read ports, whatever has been written to it. Writes aimed at register zero are dropped. The array has no reset and starts with undefined contents. Software, or the bench, writes every register it means to use before reading it.

Top module: `regfile3p`

## Requirements
- R1: When `wr_en` is 1 at a rising edge of `clk` and `wr_addr` is nonzero, the register `wr_addr` holds `wr_data` after that edge.
- R2: When `wr_en` is 0 at a rising edge, no register changes.
- R3: Read port A drives `rd_data_a` with the contents of register `rd_addr_a` combinationally. A change of `rd_addr_a` shows on the output with no clock edge.
- R4: Read port B behaves as port A does, using `rd_addr_b` and `rd_data_b`. It is independent of port A, and both ports may read the same register at the same time.
- R5: Reading register 0 on either port returns all zeros, including after any number of writes to register 0.
- R6: If a read address equals `wr_addr` while `wr_en` is 1, the read port shows the old value until the edge and the new value right after it. No bypass is applied.
- R7: The data width `DW` and the register count `NREGS` are parameters, with defaults of 32 and 32. The address width is ceil(log2(`NREGS`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Register number to write |
| wr_data | input | DW | Data to write |
| rd_addr_a | input | AW | Read port A register number |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | AW | Read port B register number |
| rd_data_b | output | DW | Read port B data |

## Verification
Some properties are checked on every cycle by assertions:
- a read of register 0 gives zero on either port;
- two ports addressing the same register agree;
- a register that was not written keeps its read value across an edge;
- a register that was written reads back the data from the previous cycle.

Other behaviour only the bench's scenarios can show, against a reference model of the array:
- the combinational response to an address change between edges;
- the old value being visible before the edge during a write to the same register;
- dropped writes to register 0 over long random sequences.

// File: rtl/regfile3p.sv
module regfile3p #(
  parameter int DW    = 32,
  parameter int NREGS = 32,
  parameter int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b
);

  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk)
    if (wr_en && wr_addr != '0 && 32'(wr_addr) < NREGS) regs[wr_addr] <= wr_data;

  assign rd_data_a = (rd_addr_a == '0 || 32'(rd_addr_a) >= NREGS) ? '0 : regs[rd_addr_a];
  assign rd_data_b = (rd_addr_b == '0 || 32'(rd_addr_b) >= NREGS) ? '0 : regs[rd_addr_b];

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R5
  a_r5_zero_a: assert property (@(posedge clk) rd_addr_a == '0 |-> rd_data_a == '0);
  a_r5_zero_b: assert property (@(posedge clk) rd_addr_b == '0 |-> rd_data_b == '0);
  // R4
  a_r4_ports_agree: assert property (@(posedge clk)
    (rd_addr_a == rd_addr_b && !$isunknown(rd_data_a)) |-> rd_data_a == rd_data_b);
  // R1
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!past_ok)
    (wr_en && wr_addr != '0 && wr_addr == rd_addr_a) |=>
      (rd_addr_a == $past(rd_addr_a)) |-> rd_data_a == $past(wr_data));
  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!past_ok)
    (!wr_en && !$isunknown(rd_data_b)) |=>
      (rd_addr_b == $past(rd_addr_b)) |-> $stable(rd_data_b));

endmodule

// File: tb/regfile3p_bench.sv
module regfile3p_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NREGS = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile3p #(.DW(DW), .NREGS(NREGS)) u_regfile3p (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (en && a != 0) model[a] = d;
    #1 wr_en = 1'b0;
  endtask

  task automatic t_reset_zero();
    rd_addr_a = 0; rd_addr_b = 0; #1;
    chk("R5 port A reg0 at start", rd_data_a, '0);
    chk("R5 port B reg0 at start", rd_data_b, '0);
  endtask

  task automatic t_fill();
    for (int i = 1; i < NREGS; i++) do_write(1'b1, AW'(i), 32'hA500_0000 + 32'(i) * 32'h0101);
    for (int i = 1; i < NREGS; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(NREGS - i); #1;
      chk("R1/R3 fill port A", rd_data_a, model[i]);
      chk("R4 fill port B", rd_data_b, model[NREGS - i]);
    end
  endtask

  task automatic t_no_enable();
    do_write(1'b0, 5'd7, 32'hDEAD_BEEF);
    rd_addr_a = 7; #1;
    chk("R2 disabled write ignored", rd_data_a, model[7]);
  endtask

  task automatic t_zero_write();
    do_write(1'b1, 5'd0, 32'hFFFF_FFFF);
    do_write(1'b1, 5'd0, 32'h1234_5678);
    rd_addr_a = 0; rd_addr_b = 0; #1;
    chk("R5 reg0 after write A", rd_data_a, '0);
    chk("R5 reg0 after write B", rd_data_b, '0);
  endtask

  task automatic t_comb_read();
    @(negedge clk);
    rd_addr_a = 3; #1;
    chk("R3 comb read A r3", rd_data_a, model[3]);
    rd_addr_a = 9; #1;
    chk("R3 comb read A r9 no edge", rd_data_a, model[9]);
    rd_addr_b = 9; #1;
    chk("R4 same reg both ports", rd_data_b, rd_data_a);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] old;
    @(negedge clk);
    old = model[12];
    rd_addr_a = 12; rd_addr_b = 12;
    wr_en = 1; wr_addr = 12; wr_data = 32'h0BAD_F00D; #1;
    chk("R6 old value before edge A", rd_data_a, old);
    chk("R6 old value before edge B", rd_data_b, old);
    @(posedge clk); model[12] = 32'h0BAD_F00D; #1; wr_en = 0;
    chk("R6 new value after edge A", rd_data_a, 32'h0BAD_F00D);
    chk("R6 new value after edge B", rd_data_b, 32'h0BAD_F00D);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wr_en = ($urandom_range(3) != 0);
      wr_addr = AW'($urandom_range(NREGS - 1));
      wr_data = $urandom;
      rd_addr_a = AW'($urandom_range(NREGS - 1));
      rd_addr_b = AW'($urandom_range(NREGS - 1)); #1;
      chk("R3 random A", rd_data_a, rd_addr_a == 0 ? '0 : model[rd_addr_a]);
      chk("R4 random B", rd_data_b, rd_addr_b == 0 ? '0 : model[rd_addr_b]);
      @(posedge clk);
      if (wr_en && wr_addr != 0) model[wr_addr] = wr_data;
      #1;
      chk("R1 random after edge A", rd_data_a, rd_addr_a == 0 ? '0 : model[rd_addr_a]);
      chk("R5 random after edge B", rd_data_b, rd_addr_b == 0 ? '0 : model[rd_addr_b]);
    end
    wr_en = 0;
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    chk("R7 address width", 32'($bits(rd_addr_a)), 32'($clog2(NREGS)));
    t_reset_zero();
    @(negedge clk);
    t_fill();
    t_no_enable();
    t_zero_write();
    t_comb_read();
    t_same_cycle();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule